// File: doc/BRIEF.md
# Tearing-Effect Start Trigger

This block decides when a display frame transfer may begin. A panel reports its scan position on one tearing-effect pin. Both horizontal and vertical sync pulses appear on that pin, and they differ only in how long they stay active. The block measures every active pulse in clock ticks and compares it against two programmed width thresholds to label the pulse as a vertical sync, a horizontal sync, or noise. It then raises a one-clock start strobe at the point the selected mode calls for.

There are three ways to trigger. In internal mode, a start request fires the strobe straight away. In frame mode, the strobe waits for the first vertical sync after the request. In line mode, the block locks onto a vertical sync, counts the horizontal syncs that follow, and fires when the count reaches a programmed line number. The vertical and horizontal classes each have their own active level, so the two kinds of pulse may use opposite polarities on the same pin. The pin is taken as synchronous to `clk`. One tick is one clock cycle.

Top module: `te_sync_trigger`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `start_o` is low and no request is pending.
- R2: When `trig_mode` is 0 (internal) and no request is pending, a `start_req` sampled on a clock edge makes `start_o` high for exactly the following cycle.
- R3: The vertical classifier treats the pin as active when it equals `vs_active_high`. The horizontal classifier treats it as active when it equals `hs_active_high`. A value of 1 means active high and 0 means active low, and the two settings are independent.
- R4: A pulse's length is the number of clock edges at which the pin was active. The pulse is judged in the cycle the pin first reads inactive. A length of at least `vs_width` makes a vertical sync. A length of at least `hs_width` but below `vs_width` makes a horizontal sync. Anything shorter is ignored. No single cycle yields both classes.
- R5: In frame mode (`trig_mode` = 1), the strobe fires on the clock edge right after the first vertical sync that completes while the request is pending. Horizontal syncs and short pulses have no effect in this mode.
- R6: In line mode, a request waits for a vertical sync, which clears the line count. Each later horizontal sync adds one to the count. The strobe fires on the edge after the horizontal sync that brings the count equal to `line_num`. If `line_num` is 0, the strobe fires after the vertical sync itself. Horizontal syncs before the first vertical sync are not counted.
- R7: Each accepted request produces exactly one strobe, one cycle wide. A `start_req` that arrives while a request is pending is ignored. Syncs that arrive while nothing is pending produce no strobe.
- R8: A request in a sync mode is dropped, with no strobe and nothing pending, in any of these cases: `hs_width` is below 2, `hs_width` equals `vs_width`, `vs_width` is below 4 in frame mode, or `vs_width` is below 2 in line mode.
- R9: The `trig_mode` encoding is: 0 internal, 1 frame mode, 2 or 3 line mode. The mode is captured when a request is accepted, so changing `trig_mode` while a request is pending has no effect on that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| te_in | input | 1 | Tearing-effect pin from the panel, synchronous to clk |
| start_req | input | 1 | Request for one transfer start |
| trig_mode | input | 2 | 0 internal, 1 frame mode, 2/3 line mode |
| vs_active_high | input | 1 | Active level of vertical sync pulses (1 = high) |
| hs_active_high | input | 1 | Active level of horizontal sync pulses (1 = high) |
| hs_width | input | TICK_W | Minimum length of a horizontal sync, in ticks |
| vs_width | input | TICK_W | Minimum length of a vertical sync, in ticks |
| line_num | input | LINE_W | Target line count for line mode |
| start_o | output | 1 | One-cycle start strobe |

## Verification
Some properties hold on every cycle, and the assertions check those. They confirm that an internal-mode request strobes on the next edge, and that a frame-mode vertical sync strobes while a request is pending. They confirm that a line-mode strobe is never issued before a vertical sync has locked the count. They also confirm that an illegal width setting leaves the block idle, that a strobe always returns the control to idle, and that the two pulse classes never coincide. The bench scenarios cover what the assertions cannot. These include the exact strobe cycle for each mode, the classification boundaries at exactly `hs_width` and `vs_width`, inverted and mixed polarities, line counting past ignored pulses, the latched mode, and the absence of strobes for ignored or refused requests.

// File: rtl/te_sync_pkg.sv
package te_sync_pkg;

  localparam int TICK_MAX_W = 16;

  localparam logic [1:0] TRIG_INTERNAL = 2'd0;
  localparam logic [1:0] TRIG_FRAME    = 2'd1;

  localparam int MIN_HS_TICKS       = 2;
  localparam int MIN_VS_TICKS_FRAME = 4;
  localparam int MIN_VS_TICKS_LINE  = 2;

  typedef enum logic {CTL_IDLE, CTL_ARMED} ctl_state_t;

  typedef enum logic [1:0] {PULSE_NONE, PULSE_HSYNC, PULSE_VSYNC} pulse_kind_t;

  // Label a finished pulse by its length against the two thresholds.
  function automatic pulse_kind_t classify_pulse(input logic [TICK_MAX_W-1:0] len,
                                                 input logic [TICK_MAX_W-1:0] hs_w,
                                                 input logic [TICK_MAX_W-1:0] vs_w);
    if (len >= vs_w) return PULSE_VSYNC;
    if (len >= hs_w) return PULSE_HSYNC;
    return PULSE_NONE;
  endfunction

  // Width settings that make the selected sync mode usable.
  function automatic logic widths_legal(input logic [1:0] mode,
                                        input logic [TICK_MAX_W-1:0] hs_w,
                                        input logic [TICK_MAX_W-1:0] vs_w);
    int unsigned vs_min;
    if (mode == TRIG_INTERNAL) return 1'b1;
    vs_min = (mode == TRIG_FRAME) ? MIN_VS_TICKS_FRAME : MIN_VS_TICKS_LINE;
    return (hs_w >= TICK_MAX_W'(MIN_HS_TICKS)) && (hs_w != vs_w) &&
           (vs_w >= TICK_MAX_W'(vs_min));
  endfunction

endpackage

// File: rtl/te_pulse_meter.sv
module te_pulse_meter #(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              te_in,
  input  logic              active_high,
  output logic              pulse_end,
  output logic [TICK_W-1:0] pulse_len
);
  localparam logic [TICK_W-1:0] LEN_MAX = {TICK_W{1'b1}};

  logic              active;
  logic [TICK_W-1:0] len_q;

  assign active = (te_in == active_high);

  // Saturating count of active samples; cleared on the first inactive one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                len_q <= '0;
    else if (!active)          len_q <= '0;
    else if (len_q != LEN_MAX) len_q <= len_q + TICK_W'(1);
  end

  assign pulse_end = !active && (len_q != '0);
  assign pulse_len = len_q;

endmodule

// File: rtl/te_line_tracker.sv
module te_line_tracker #(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              vs_evt,
  input  logic              hs_evt,
  output logic              locked,
  output logic [LINE_W-1:0] line_cnt
);
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      line_cnt <= '0;
    end else if (clear) begin
      locked   <= 1'b0;
      line_cnt <= '0;
    end else if (vs_evt) begin
      locked   <= 1'b1;
      line_cnt <= '0;
    end else if (hs_evt && locked && line_cnt != LINE_MAX) begin
      line_cnt <= line_cnt + LINE_W'(1);
    end
  end

endmodule

// File: rtl/te_start_ctrl.sv
module te_start_ctrl
  import te_sync_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [1:0]        trig_mode,
  input  logic              cfg_ok,
  input  logic              vs_evt,
  input  logic              hs_evt,
  input  logic              locked,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [LINE_W-1:0] line_num,
  output logic              accept,
  output logic              start_o
);
  ctl_state_t st_q, st_d;
  logic [1:0] mode_q;
  logic       fire;

  always_comb begin
    fire   = 1'b0;
    accept = 1'b0;
    st_d   = st_q;
    if (st_q == CTL_IDLE) begin
      if (start_req) begin
        if (trig_mode == TRIG_INTERNAL) fire   = 1'b1;
        else if (cfg_ok)                accept = 1'b1;
      end
      if (accept) st_d = CTL_ARMED;
    end else begin
      if (!mode_q[1])  fire = vs_evt;
      else if (vs_evt) fire = (line_num == '0);
      else             fire = hs_evt && locked && ((line_cnt + LINE_W'(1)) == line_num);
      if (fire) st_d = CTL_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CTL_IDLE;
      mode_q  <= TRIG_INTERNAL;
      start_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_o <= fire;
      if (accept) mode_q <= trig_mode;
    end
  end

  // R2: internal trigger strobes on the next edge
  p_internal_immediate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CTL_IDLE && start_req && trig_mode == TRIG_INTERNAL) |=> start_o);

  // R5: a completed vertical sync releases a pending frame-mode request
  p_frame_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CTL_ARMED && !mode_q[1] && vs_evt) |=> start_o);

  // R6: a line-mode strobe needs a vertical sync lock
  p_line_needs_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && $past(st_q == CTL_ARMED) && $past(mode_q[1])) |-> $past(locked || vs_evt));

  // R7: after a strobe nothing is pending
  p_strobe_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (st_q == CTL_IDLE));

  // R8: illegal widths leave the block idle
  p_refuse_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CTL_IDLE && start_req && trig_mode != TRIG_INTERNAL && !cfg_ok)
      |=> (st_q == CTL_IDLE && !start_o));

endmodule

// File: rtl/te_sync_trigger.sv
module te_sync_trigger
  import te_sync_pkg::*;
#(
  parameter int TICK_W = 8,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              te_in,
  input  logic              start_req,
  input  logic [1:0]        trig_mode,
  input  logic              vs_active_high,
  input  logic              hs_active_high,
  input  logic [TICK_W-1:0] hs_width,
  input  logic [TICK_W-1:0] vs_width,
  input  logic [LINE_W-1:0] line_num,
  output logic              start_o
);
  localparam int N_CLASSES = 2;  // index 0: vertical, 1: horizontal

  logic [N_CLASSES-1:0]             pol;
  logic [N_CLASSES-1:0]             meter_end;
  logic [N_CLASSES-1:0][TICK_W-1:0] meter_len;
  pulse_kind_t                      vs_kind, hs_kind;
  logic                             vs_evt, hs_evt, cfg_ok, accept, locked;
  logic [LINE_W-1:0]                line_cnt;

  assign pol = {hs_active_high, vs_active_high};

  for (genvar g = 0; g < N_CLASSES; g++) begin : g_meter
    te_pulse_meter #(.TICK_W(TICK_W)) u_meter (
      .clk         (clk),
      .rst_n       (rst_n),
      .te_in       (te_in),
      .active_high (pol[g]),
      .pulse_end   (meter_end[g]),
      .pulse_len   (meter_len[g])
    );
  end

  assign vs_kind = classify_pulse(TICK_MAX_W'(meter_len[0]), TICK_MAX_W'(hs_width),
                                  TICK_MAX_W'(vs_width));
  assign hs_kind = classify_pulse(TICK_MAX_W'(meter_len[1]), TICK_MAX_W'(hs_width),
                                  TICK_MAX_W'(vs_width));
  assign vs_evt  = meter_end[0] && (vs_kind == PULSE_VSYNC);
  assign hs_evt  = meter_end[1] && (hs_kind == PULSE_HSYNC);
  assign cfg_ok  = widths_legal(trig_mode, TICK_MAX_W'(hs_width), TICK_MAX_W'(vs_width));

  te_line_tracker #(.LINE_W(LINE_W)) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .vs_evt   (vs_evt),
    .hs_evt   (hs_evt),
    .locked   (locked),
    .line_cnt (line_cnt)
  );

  te_start_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .trig_mode (trig_mode),
    .cfg_ok    (cfg_ok),
    .vs_evt    (vs_evt),
    .hs_evt    (hs_evt),
    .locked    (locked),
    .line_cnt  (line_cnt),
    .line_num  (line_num),
    .accept    (accept),
    .start_o   (start_o)
  );

  // R4: one pulse end never yields both classes
  p_classes_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(vs_evt && hs_evt));

endmodule

// File: tb/te_sync_trigger_bench.sv
module te_sync_trigger_bench;
  localparam int TICK_W = 8;
  localparam int LINE_W = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              te_in = 1'b0;
  logic              start_req = 1'b0;
  logic [1:0]        trig_mode = 2'd0;
  logic              vs_hi = 1'b1;
  logic              hs_hi = 1'b1;
  logic [TICK_W-1:0] hs_w = 8'd3;
  logic [TICK_W-1:0] vs_w = 8'd6;
  logic [LINE_W-1:0] line_num = '0;
  logic              start_o;

  int    cyc = 0;
  int    n_checks = 0;
  int    n_fail = 0;
  int    nstrobe = 0;
  int    base = 0;
  bit    done = 0;
  int    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  te_sync_trigger #(.TICK_W(TICK_W), .LINE_W(LINE_W)) u_te_sync_trigger (
    .clk(clk), .rst_n(rst_n), .te_in(te_in), .start_req(start_req),
    .trig_mode(trig_mode), .vs_active_high(vs_hi), .hs_active_high(hs_hi),
    .hs_width(hs_w), .vs_width(vs_w), .line_num(line_num), .start_o(start_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive the pin to lvl now (at a falling edge) for n sampling edges;
  // optionally expect the strobe that this level change releases.
  task automatic hold(input bit lvl, input int n, input bit expect_strobe, input string tag);
    te_in = lvl;
    if (expect_strobe) begin
      exp_q.push_back(cyc + 1);
      tag_q.push_back(tag);
    end
    repeat (n) @(negedge clk);
  endtask

  task automatic req(input bit expect_strobe, input string tag);
    start_req = 1'b1;
    if (expect_strobe) begin
      exp_q.push_back(cyc + 1);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    start_req = 1'b0;
  endtask

  task automatic window_check(input int added, input string tag);
    #1;
    chk(nstrobe == base + added, tag, nstrobe - base, added);
    base = nstrobe;
  endtask

  // Scoreboard monitor: every strobe must match the head of the queue.
  always @(negedge clk) begin : monitor
    int    e;
    string t;
    if (rst_n) begin
      if (start_o) begin
        nstrobe++;
        n_checks++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R7: unexpected strobe at cycle %0d, expected none", cyc);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (e != cyc) begin
            n_fail++;
            $display("FAIL %s: strobe at cycle %0d, expected cycle %0d", t, cyc, e);
          end
        end
      end else if (exp_q.size() != 0 && exp_q[0] <= cyc) begin
        n_checks++;
        n_fail++;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        $display("FAIL %s: no strobe at cycle %0d, expected cycle %0d", t, cyc, e);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(start_o == 1'b0, "R1 during reset", start_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(start_o == 1'b0, "R1 after reset", start_o, 0);
    base = nstrobe;

    // R2: internal trigger, two separate requests
    trig_mode = 2'd0;
    req(1, "R2");
    @(negedge clk);
    req(1, "R2");
    repeat (3) @(negedge clk);
    window_check(2, "R2 count");

    // R5: frame mode ignores hsync and short pulses, fires on vsync end
    trig_mode = 2'd1;
    req(0, "");
    hold(1, 4, 0, ""); hold(0, 3, 0, "");
    hold(1, 2, 0, ""); hold(0, 3, 0, "");
    hold(1, 8, 0, ""); hold(0, 5, 1, "R5");
    window_check(1, "R5 count");
    // R7: vsync with nothing pending gives no strobe
    hold(1, 8, 0, ""); hold(0, 4, 0, "");
    window_check(0, "R7 idle vsync");

    // R7: second request while pending is ignored
    req(0, ""); req(0, "");
    hold(1, 8, 0, ""); hold(0, 3, 1, "R7");
    hold(1, 8, 0, ""); hold(0, 3, 0, "");
    window_check(1, "R7 single strobe");

    // R4: length vs_width-1 is not vsync, exactly vs_width is
    req(0, "");
    hold(1, 5, 0, ""); hold(0, 3, 0, "");
    hold(1, 6, 0, ""); hold(0, 3, 1, "R4");
    window_check(1, "R4 boundary");

    // R6: line mode, line 3, hsync before vsync not counted, short pulse ignored
    trig_mode = 2'd2; line_num = 11'd3;
    req(0, "");
    hold(1, 4, 0, ""); hold(0, 2, 0, "");
    hold(1, 8, 0, ""); hold(0, 2, 0, "");
    hold(1, 3, 0, ""); hold(0, 2, 0, "");
    hold(1, 2, 0, ""); hold(0, 2, 0, "");
    hold(1, 3, 0, ""); hold(0, 2, 0, "");
    hold(1, 3, 0, ""); hold(0, 2, 1, "R6 line3");
    window_check(1, "R6 line3 count");

    // R6: line 0 fires on the vsync itself
    line_num = 11'd0;
    req(0, "");
    hold(1, 8, 0, ""); hold(0, 3, 1, "R6 line0");
    window_check(1, "R6 line0 count");

    // R9: mode 3 acts as line mode
    trig_mode = 2'd3; line_num = 11'd1;
    req(0, "");
    hold(1, 8, 0, ""); hold(0, 2, 0, "");
    hold(1, 4, 0, ""); hold(0, 2, 1, "R9 mode3");
    window_check(1, "R9 mode3 count");

    // R9: mode latched at acceptance
    trig_mode = 2'd1;
    req(0, "");
    trig_mode = 2'd0;
    hold(1, 8, 0, ""); hold(0, 3, 1, "R9 latched");
    window_check(1, "R9 latched count");

    // R8: illegal widths refuse requests
    trig_mode = 2'd1; hs_w = 8'd2; vs_w = 8'd3;
    req(0, "");
    hold(1, 8, 0, ""); hold(0, 3, 0, "");
    window_check(0, "R8 frame vs<4");
    trig_mode = 2'd2; line_num = 11'd0;
    req(0, "");
    hold(1, 8, 0, ""); hold(0, 3, 1, "R8 line vs=3 legal");
    window_check(1, "R8 line legal count");
    hs_w = 8'd4; vs_w = 8'd4;
    req(0, "");
    hold(1, 8, 0, ""); hold(0, 3, 0, "");
    window_check(0, "R8 equal widths");
    hs_w = 8'd1; vs_w = 8'd6;
    req(0, "");
    hold(1, 8, 0, ""); hold(0, 3, 0, "");
    window_check(0, "R8 hs<2");
    hs_w = 8'd3;

    // R3: active-low vertical sync in frame mode
    trig_mode = 2'd1; vs_hi = 1'b0;
    hold(1, 4, 0, "");
    req(0, "");
    hold(0, 2, 0, ""); hold(1, 3, 0, "");
    hold(0, 8, 0, ""); hold(1, 3, 1, "R3 vs low");
    window_check(1, "R3 vs low count");

    // R3: active-high vsync with active-low hsync in line mode, line 2
    vs_hi = 1'b1; hs_hi = 1'b0; trig_mode = 2'd2; line_num = 11'd2;
    hold(0, 10, 0, "");
    req(0, "");
    hold(1, 8, 0, ""); hold(0, 4, 0, "");
    hold(1, 1, 0, ""); hold(0, 4, 0, "");
    hold(1, 3, 1, "R3 mixed");
    hs_hi = 1'b1;
    hold(0, 4, 0, "");
    window_check(1, "R3 mixed count");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all expected strobes seen", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule